// File: doc/BRIEF.md
# SPI Master Controller with Shallow Word Buffers

This block is a register-mapped serial peripheral interface master. Software fills a small transmit buffer with words through a 32-bit register port. The block shifts each word out on the serial data output while it shifts a word in from the serial data input. Each received word is placed in a receive buffer of the same depth, and software pops it from the data register.

The block has two operating modes. In configuration mode the clock divider, word length (8 or 16 bits), clock idle level, sampling phase and bit order may be changed, and no word is started. In active mode, words leave the transmit buffer one after another. A clear bit in the mode register empties both buffers. A receive fill threshold sets a status flag, and when that flag is enabled it raises an interrupt line. Typical use: enter configuration mode with a clear, program the shape of the transfer, queue up to four words, switch to active mode, wait for the idle flag or the interrupt, then drain the received words.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the mode register (offset 0x00) reads 0x40 (configuration mode), status (offset 0x14) reads 0x00008004, and irq, spi_sck and spi_mosi are low.
- R2: The mode field is bits [7:6] of offset 0x00, where 01 is configuration and 10 is active. A word leaves the transmit buffer only in active mode. Words queued in configuration mode stay queued and cause no SCK edge.
- R3: Writing offset 0x00 with bit 0 set empties the transmit and receive buffers, so both count fields in status read 0.
- R4: Writes to offset 0x04 (bit 0 clock idle level, bit 1 phase, bit 2 LSB-first, bit 9 interrupt enable, bits [13:12] threshold) and offset 0x08 (bits [15:8] divider n, bits [4:0] word length) take effect only in configuration mode. In active mode they leave the read-back value unchanged.
- R5: Each bit lasts n+1 clock cycles, so SCK runs at the clock rate divided by n+1. A divider of 0 acts as 1.
- R6: Each buffer holds four words. A data write (offset 0x18) to a full transmit buffer is dropped. A data read from an empty receive buffer returns 0 and leaves the counts unchanged.
- R7: A word length of 16 selects 16-bit words and any other value selects 8-bit words. In 8-bit mode only bits [7:0] of the written word are sent, and received words read with bits [31:8] zero.
- R8: Status bit 14 is set while the receive count is at least threshold+1. irq follows bit 14 AND the enable bit, one cycle later.
- R9: SCK idles at the programmed level. With phase 0, data is sampled on the first edge of each bit. With phase 1, data is sampled on the second edge.
- R10: With bit order MSB-first the top bit of the word goes out first. With LSB-first, bit 0 goes out first. The same order applies to reception.
- R11: Status bit 15 is set while the transmit buffer has room. Bits [13:11] give the transmit count, bits [10:8] give the receive count, and bit 2 is set when no word is shifting and the transmit buffer is empty.
- R12: Data reads return the received words in arrival order, one word per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| irq | output | 1 | Receive threshold interrupt |

## Verification
The bench builds the block with its defaults: four-word buffers and a 5-bit address. With these values a fifth queued word reaches the full case, and every threshold from one to four words can be reached in a single burst. An 8-bit divider brings the 0-as-1 case within reach, along with both odd and even bit periods, whose high and low phases are split unevenly or evenly. A behavioural slave in the bench captures the output words on the programmed sampling edge and times every bit period. It returns known words, so that each of the four clock shapes can be checked in both bit orders and both word lengths.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  localparam int WORD_W = 16;
  localparam int DIV_W  = 8;

  typedef enum logic [1:0] {
    OPM_OFF = 2'b00,
    OPM_CFG = 2'b01,
    OPM_RUN = 2'b10,
    OPM_BAD = 2'b11
  } opmode_e;

  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic             lsb_first;
    logic             wide;
    logic [DIV_W-1:0] div;
  } shift_cfg_t;

  localparam logic [7:0] OFS_MODE  = 8'h00;
  localparam logic [7:0] OFS_CTLA  = 8'h04;
  localparam logic [7:0] OFS_CTLB  = 8'h08;
  localparam logic [7:0] OFS_STAT  = 8'h14;
  localparam logic [7:0] OFS_DATA  = 8'h18;

endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign push_ok = push && !clr && (count != CNT_W'(DEPTH));
  assign pop_ok  = pop && !clr && (count != '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok)
        wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)
        rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/spi_fifo_shifter.sv
module spi_fifo_shifter
  import spi_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  shift_cfg_t        cfg,
  input  logic              start,
  input  logic [WORD_W-1:0] start_word,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o
);

  localparam int HALF_W = WORD_W / 2;
  localparam int BIT_W  = $clog2(WORD_W);

  logic [DIV_W-1:0]  cnt, div_eff;
  logic [DIV_W:0]    cnt_nx, half;
  logic [BIT_W-1:0]  bit_idx, last_bit;
  logic [WORD_W-1:0] txsh, rxsh, load_word, tx_shifted, rx_shifted, rx_pack;
  logic              first_bit, next_bit, act_nx;

  assign div_eff  = (cfg.div == '0) ? DIV_W'(1) : cfg.div;
  assign cnt_nx   = {1'b0, cnt} + 1'b1;
  assign half     = ({1'b0, div_eff} + 1'b1) >> 1;
  assign act_nx   = cfg.cpha ? (cnt_nx < half) : (cnt_nx >= half);
  assign last_bit = cfg.wide ? BIT_W'(WORD_W - 1) : BIT_W'(HALF_W - 1);

  always_comb begin
    if (cfg.lsb_first || cfg.wide) load_word = start_word;
    else                           load_word = {start_word[HALF_W-1:0], {HALF_W{1'b0}}};
    first_bit  = cfg.lsb_first ? load_word[0] : load_word[WORD_W-1];
    tx_shifted = cfg.lsb_first ? (txsh >> 1) : (txsh << 1);
    next_bit   = cfg.lsb_first ? txsh[1] : txsh[WORD_W-2];
    rx_shifted = cfg.lsb_first ? {miso_i, rxsh[WORD_W-1:1]} : {rxsh[WORD_W-2:0], miso_i};
    if (cfg.wide)           rx_pack = rxsh;
    else if (cfg.lsb_first) rx_pack = {{HALF_W{1'b0}}, rxsh[WORD_W-1:HALF_W]};
    else                    rx_pack = {{HALF_W{1'b0}}, rxsh[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy_o    <= 1'b0;
      cnt       <= '0;
      bit_idx   <= '0;
      txsh      <= '0;
      rxsh      <= '0;
      mosi_o    <= 1'b0;
      done_o    <= 1'b0;
      sck_o     <= rst ? 1'b0 : cfg.cpol;
      if (rst) rx_word_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        sck_o <= cfg.cpol;
        if (start) begin
          busy_o  <= 1'b1;
          cnt     <= '0;
          bit_idx <= '0;
          txsh    <= load_word;
          rxsh    <= '0;
          mosi_o  <= first_bit;
          sck_o   <= cfg.cpol ^ cfg.cpha;
        end
      end else if (cnt == div_eff) begin
        cnt <= '0;
        if (bit_idx == last_bit) begin
          busy_o    <= 1'b0;
          done_o    <= 1'b1;
          sck_o     <= cfg.cpol;
          mosi_o    <= 1'b0;
          rx_word_o <= rx_pack;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          txsh    <= tx_shifted;
          mosi_o  <= next_bit;
          sck_o   <= cfg.cpol ^ cfg.cpha;
        end
      end else begin
        cnt   <= cnt + 1'b1;
        sck_o <= cfg.cpol ^ act_nx;
        if (cnt_nx == half) rxsh <= rx_shifted;
      end
    end
  end

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              irq
);

  opmode_e           mode_q;
  shift_cfg_t        cfg_q;
  logic [4:0]        wlen_q;
  logic [1:0]        lvl_q;
  logic              irq_en_q;

  logic [ADDR_W-1:0] word_addr;
  logic              wr_mode, wr_ctla, wr_ctlb, wr_data, rd_data, cfg_open, clr_pulse;
  logic [WORD_W-1:0] tx_head, rx_head, rx_word;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic              sh_busy, sh_done, start, rx_hit, tx_room, idle;
  logic [31:0]       rd_mux, stat_word;

  assign word_addr = {bus_addr[ADDR_W-1:2], 2'b00};
  assign wr_mode   = bus_en && bus_we && (word_addr == ADDR_W'(OFS_MODE));
  assign wr_ctla   = bus_en && bus_we && (word_addr == ADDR_W'(OFS_CTLA));
  assign wr_ctlb   = bus_en && bus_we && (word_addr == ADDR_W'(OFS_CTLB));
  assign wr_data   = bus_en && bus_we && (word_addr == ADDR_W'(OFS_DATA));
  assign rd_data   = bus_en && !bus_we && (word_addr == ADDR_W'(OFS_DATA));
  assign cfg_open  = (mode_q == OPM_CFG);
  assign clr_pulse = wr_mode && bus_wdata[0];

  assign tx_room = (tx_cnt != CNT_W'(DEPTH));
  assign rx_hit  = (3'(rx_cnt) >= ({1'b0, lvl_q} + 3'd1));
  assign idle    = !sh_busy && (tx_cnt == '0);
  assign start   = (mode_q == OPM_RUN) && !sh_busy && (tx_cnt != '0) && !clr_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= OPM_CFG;
      cfg_q    <= '{cpol: 1'b0, cpha: 1'b0, lsb_first: 1'b0, wide: 1'b0, div: DIV_W'(1)};
      wlen_q   <= 5'd8;
      lvl_q    <= 2'd0;
      irq_en_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= opmode_e'(bus_wdata[7:6]);
      if (wr_ctla && cfg_open) begin
        cfg_q.cpol      <= bus_wdata[0];
        cfg_q.cpha      <= bus_wdata[1];
        cfg_q.lsb_first <= bus_wdata[2];
        irq_en_q        <= bus_wdata[9];
        lvl_q           <= bus_wdata[13:12];
      end
      if (wr_ctlb && cfg_open) begin
        cfg_q.div  <= bus_wdata[15:8];
        cfg_q.wide <= (bus_wdata[4:0] == 5'd16);
        wlen_q     <= bus_wdata[4:0];
      end
    end
  end

  spi_fifo_buf #(.W(WORD_W), .DEPTH(DEPTH)) u_txbuf (
    .clk(clk), .rst(rst), .clr(clr_pulse),
    .push(wr_data), .push_data(bus_wdata[WORD_W-1:0]),
    .pop(start), .head(tx_head), .count(tx_cnt)
  );

  spi_fifo_buf #(.W(WORD_W), .DEPTH(DEPTH)) u_rxbuf (
    .clk(clk), .rst(rst), .clr(clr_pulse),
    .push(sh_done), .push_data(rx_word),
    .pop(rd_data), .head(rx_head), .count(rx_cnt)
  );

  spi_fifo_shifter u_shift (
    .clk(clk), .rst(rst), .abort(clr_pulse), .cfg(cfg_q),
    .start(start), .start_word(tx_head), .miso_i(spi_miso),
    .busy_o(sh_busy), .sck_o(spi_sck), .mosi_o(spi_mosi),
    .done_o(sh_done), .rx_word_o(rx_word)
  );

  always_comb begin
    stat_word        = '0;
    stat_word[15]    = tx_room;
    stat_word[14]    = rx_hit;
    stat_word[13:11] = 3'(tx_cnt);
    stat_word[10:8]  = 3'(rx_cnt);
    stat_word[2]     = idle;
    rd_mux = '0;
    case (word_addr)
      ADDR_W'(OFS_MODE): rd_mux[7:6] = mode_q;
      ADDR_W'(OFS_CTLA): begin
        rd_mux[0]     = cfg_q.cpol;
        rd_mux[1]     = cfg_q.cpha;
        rd_mux[2]     = cfg_q.lsb_first;
        rd_mux[9]     = irq_en_q;
        rd_mux[13:12] = lvl_q;
      end
      ADDR_W'(OFS_CTLB): begin
        rd_mux[15:8] = cfg_q.div;
        rd_mux[4:0]  = wlen_q;
      end
      ADDR_W'(OFS_STAT): rd_mux = stat_word;
      ADDR_W'(OFS_DATA): rd_mux = (rx_cnt != '0) ? 32'(rx_head) : 32'd0;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_en && !bus_we) bus_rdata <= rd_mux;
      irq <= irq_en_q && rx_hit;
    end
  end

  logic unused_ok;
  assign unused_ok = ^{bus_addr[1:0], bus_wdata[31:16]};

endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic [1:0]       mode,
  input logic             clr,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             sck,
  input logic             cpol,
  input logic             irq
);

  a_r2_start_only_active: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(mode) == 2'b10);

  a_r3_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (tx_cnt == '0) && (rx_cnt == '0));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));

  a_r8_irq_needs_data: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(rx_cnt) != '0);

  a_r9_sck_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cpol)) |-> sck == cpol);

endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(sh_busy), .mode(mode_q), .clr(clr_pulse),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .sck(spi_sck), .cpol(cfg_q.cpol), .irq(irq)
);

// File: tb/test_spi_fifo_master.sv
module test_spi_fifo_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, irq;
  logic        spi_miso = 1'b0;

  spi_fifo_master i_spi_fifo_master (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq)
  );

  always #5 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // behavioural slave
  bit          s_cpol, s_cpha, s_lsb, s_wide, armed;
  int          s_div, k, sidx, words_seen, sck_edges, last_cyc;
  logic [15:0] swords [8];
  logic [15:0] mwords [8];
  logic [15:0] cap;
  logic [15:0] exp_mosi[$];
  logic        sck_prev = 1'b0;

  function automatic int wbits();
    return s_wide ? 16 : 8;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (armed && spi_sck != sck_prev && spi_sck == (s_cpha ? s_cpol : ~s_cpol)) begin
        int pos;
        sck_edges++;
        if (k > 0) chk("R5 bit period", 32'(cyc - last_cyc), 32'((s_div == 0 ? 1 : s_div) + 1));
        last_cyc = cyc;
        pos = s_lsb ? k : wbits() - 1 - k;
        cap[pos] = spi_mosi;
        k++;
        if (k == wbits()) begin
          logic [15:0] e;
          e = (exp_mosi.size() != 0) ? exp_mosi.pop_front() : 16'hxxxx;
          chk("R7/R9/R10 wire word", 32'(cap), 32'(e));
          k = 0;
          cap = '0;
          sidx++;
          words_seen++;
        end
      end
      sck_prev = spi_sck;
      spi_miso = swords[sidx % 8][s_lsb ? k : wbits() - 1 - k];
    end
  end

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic xfer(input bit cpol, input bit cpha, input bit lsb, input bit wide,
                      input int div, input int nw, input int lvl, input bit ie,
                      input bit drain, input int seed);
    logic [31:0] r;
    int edges0;
    for (int i = 0; i < 8; i++) begin
      mwords[i] = 16'hA5C3 ^ 16'(i * 16'h1357 + seed);
      swords[i] = 16'h3C96 ^ 16'(i * 16'h0BAD + seed * 7);
    end
    bus_write(5'h04, {18'd0, 2'(lvl), 2'd0, ie, 6'd0, lsb, cpha, cpol});
    bus_write(5'h08, {16'd0, 8'(div), 3'd0, wide ? 5'd16 : 5'd8});
    s_cpol = cpol; s_cpha = cpha; s_lsb = lsb; s_wide = wide; s_div = div;
    k = 0; sidx = 0; cap = '0; words_seen = 0;
    for (int i = 0; i < nw; i++) begin
      exp_mosi.push_back(wide ? mwords[i] : {8'd0, mwords[i][7:0]});
      bus_write(5'h18, {16'hFFFF, mwords[i]});
    end
    edges0 = sck_edges;
    repeat (30) @(negedge clk);
    armed = 1;
    bus_read(5'h14, r);
    chk("R2 queued in config", 32'(r[13:11]), 32'(nw));
    chk("R2 no SCK in config", 32'(sck_edges - edges0), 0);
    bus_write(5'h00, 32'h80);
    for (int g = 0; g < 3000; g++) begin
      bus_read(5'h14, r);
      if (r[2]) break;
    end
    chk("R11 idle flag", 32'(r[2]), 1);
    repeat (4) @(negedge clk);
    armed = 0;
    bus_write(5'h00, 32'h40);
    chk("R2 words shifted", 32'(words_seen), 32'(nw));
    bus_read(5'h14, r);
    chk("R11 rx count", 32'(r[10:8]), 32'(nw));
    chk("R8 threshold flag", 32'(r[14]), 32'(nw >= lvl + 1));
    chk("R8 irq", 32'(irq), 32'(ie && (nw >= lvl + 1)));
    if (drain) begin
      for (int i = 0; i < nw; i++) begin
        bus_read(5'h18, r);
        chk("R12/R7 rx word", r, wide ? {16'd0, swords[i]} : {24'd0, swords[i][7:0]});
      end
      repeat (2) @(negedge clk);
      chk("R8 irq after drain", 32'(irq), 0);
    end
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 sck", 32'(spi_sck), 0);
    chk("R1 mosi", 32'(spi_mosi), 0);
    bus_read(5'h00, r); chk("R1 mode", r, 32'h40);
    bus_read(5'h14, r); chk("R1 status", r, 32'h8004);

    // R4 configuration writes gated by mode
    bus_write(5'h04, 32'h2203);
    bus_read(5'h04, r); chk("R4 ctla in config", r, 32'h2203);
    bus_write(5'h00, 32'h80);
    bus_write(5'h04, 32'h1004);
    bus_write(5'h08, 32'h0910);
    bus_read(5'h04, r); chk("R4 ctla ignored", r, 32'h2203);
    bus_read(5'h08, r); chk("R4 ctlb ignored", r, 32'h0108);
    bus_write(5'h00, 32'h40);
    bus_write(5'h04, 32'h0);
    repeat (3) @(negedge clk);

    // R6 empty read
    bus_read(5'h18, r); chk("R6 empty read", r, 0);
    bus_read(5'h14, r); chk("R6 counts after empty read", 32'(r[10:8]), 0);

    xfer(0, 0, 0, 0, 3, 4, 3, 1, 1, 1);
    xfer(1, 1, 1, 1, 2, 3, 3, 1, 1, 2);
    xfer(0, 1, 0, 1, 0, 2, 0, 1, 1, 3);
    xfer(1, 0, 1, 0, 6, 4, 1, 0, 1, 4);
    xfer(0, 0, 1, 1, 5, 1, 0, 0, 1, 5);

    // R6 full transmit buffer, R3 clear
    xfer(0, 0, 0, 0, 1, 2, 3, 0, 0, 6);
    for (int i = 0; i < 5; i++) bus_write(5'h18, 32'(i));
    bus_read(5'h14, r);
    chk("R6 tx count capped", 32'(r[13:11]), 4);
    chk("R11 no room", 32'(r[15]), 0);
    chk("R11 rx count before clear", 32'(r[10:8]), 2);
    bus_write(5'h00, 32'h41);
    bus_read(5'h14, r);
    chk("R3 counts cleared", 32'(r[13:8]), 0);
    chk("R3 room after clear", 32'(r[15]), 1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule